// File: doc/BRIEF.md
# PCI Window DMA Address Translator

This block turns addresses seen on a PCI bus into system DMA addresses. Four programmable windows are each described by three registers: a base, a size mask and a translated base. A window either maps its range directly onto a region of system memory, or it maps through a page table in memory (scatter-gather). In scatter-gather mode the block computes the address of an 8-byte page-table entry and reads that entry over a simple request/response memory port. It then combines the entry with the page offset of the bus address to form the result.

Translation requests arrive on a valid/ready input. The input applies back-pressure only while a scatter-gather entry fetch is outstanding. In every other cycle `req_ready` is high, so direct and pass-through requests can be issued back to back, one per cycle. The result port has a valid flag and no ready; the consumer must take each result in the cycle it is shown. The memory port holds its request level and address until the cycle that carries `mem_rsp_valid`.

Configuration uses a 64-bit register port addressed by byte offset. Read data and the error flag appear in the cycle after the access.

Top module: `pci_win_xlate`

## Requirements
- R1: After reset, all twelve window registers read zero, the control register reads 64'h0000_0021_0010_0000, `rsp_valid` and `mem_req_valid` are low, and `req_ready` is high.
- R2: A register is selected by `cfg_addr >> 6`. Index 0..3 selects window base 0..3, index 4..7 selects size mask 0..3, index 8..11 selects translated base 0..3, and index 12 selects the control register. An access of size code 3 (8 bytes) writes the full 64 bits, or returns them on `cfg_rdata` in the next cycle. Size codes 0, 1 and 2 mean 1, 2 and 4 bytes.
- R3: An access is rejected if its size code is not 3, if `cfg_addr[5:0]` is non-zero, or if its index is above 12. A rejected access changes no register. In the next cycle it drives `cfg_rdata` to zero and raises `cfg_err`, which stays high for that one cycle only.
- R4: A window's compare mask is the inverse of its size mask over bits 31:20. A window matches when the bus address and the window base agree on every compare-mask bit. Bus address bits outside 31:20 take no part in the match.
- R5: Bit 0 of a window base enables the window; a disabled window never matches. Among matching windows, the lowest index is used.
- R6: With base bit 1 clear, the window maps directly. The offset mask is size-mask bits 31:20 together with bits 19:0. The result takes the offset-mask bits from the bus address and all other bits from the translated base.
- R7: With base bit 1 set, the entry address is the OR of two terms. The first is the translated base with bits cleared under ((size-mask bits 31:20) >> 10) | 0x3FF. The second is (bus address AND (size-mask bits 31:20 OR bits 19:13))) >> 10. `mem_req_valid` holds with a stable `mem_req_addr` until `mem_rsp_valid`.
- R8: The scatter-gather result is the entry with bit 0 cleared, shifted left by 12, ORed with bus address bits 12:0. It appears with `rsp_valid` in the cycle after `mem_rsp_valid`.
- R9: Every windowed result, direct or scatter-gather, is truncated to its low 34 bits.
- R10: When no enabled window matches, the full 64-bit bus address is returned unchanged.
- R11: Direct and pass-through results appear with `rsp_valid` one cycle after acceptance, and a new request may be accepted in that same cycle. `req_ready` is low while an entry fetch is outstanding.
- R12: A translation accepted in the same cycle as a register write uses the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Register access strobe |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 10 | Byte offset of the access from the block base |
| cfg_size | input | 2 | Access size code (3 = 8 bytes) |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data, valid the cycle after a read |
| cfg_err | output | 1 | One-cycle flag for a rejected access |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translation request accepted when high with req_valid |
| req_addr | input | 64 | Bus address to translate |
| rsp_valid | output | 1 | Translated address valid |
| rsp_addr | output | 64 | Translated address |
| mem_req_valid | output | 1 | Page-table entry read request |
| mem_req_addr | output | 64 | Page-table entry address |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Entry read data |

## Verification
Register updates and translation acceptance can fall in the same clock edge: a write to a window's translated base can land in the cycle a request that uses that window is accepted. The bench provokes this by driving a write and a request together. It judges the result against the old translated base, then issues a second request and expects the new base. Back-to-back direct requests, and the stall while an entry fetch is outstanding, cover the overlap between a response being shown and the next request being accepted.

// File: rtl/pwx_pkg.sv
package pwx_pkg;
  localparam int DW = 64;
  localparam logic [1:0] SZ_FULL = 2'd3;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } pwx_state_e;
endpackage

// File: rtl/pwx_regs.sv
module pwx_regs
  import pwx_pkg::*;
#(
  parameter int NWIN = 4,
  parameter int AW   = 10,
  parameter logic [DW-1:0] CTRL_RST = 64'h0000_0021_0010_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_valid,
  input  logic          cfg_write,
  input  logic [AW-1:0] cfg_addr,
  input  logic [1:0]    cfg_size,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          cfg_err,
  output logic [DW-1:0] win_base  [NWIN],
  output logic [DW-1:0] win_mask  [NWIN],
  output logic [DW-1:0] win_tbase [NWIN]
);
  localparam int STRIDE_SH = 6;
  localparam int IDX_W     = AW - STRIDE_SH;
  localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(3 * NWIN);

  logic [IDX_W-1:0] idx;
  logic             acc_ok;
  logic [DW-1:0]    ctrl_q;
  logic [DW-1:0]    rd_val;

  assign idx    = cfg_addr[AW-1:STRIDE_SH];
  assign acc_ok = (cfg_size == SZ_FULL) && (cfg_addr[STRIDE_SH-1:0] == '0) &&
                  (idx <= CTRL_IDX);

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (idx == IDX_W'(i))            rd_val = win_base[i];
      if (idx == IDX_W'(NWIN + i))     rd_val = win_mask[i];
      if (idx == IDX_W'(2 * NWIN + i)) rd_val = win_tbase[i];
    end
    if (idx == CTRL_IDX) rd_val = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        win_base[i]  <= '0;
        win_mask[i]  <= '0;
        win_tbase[i] <= '0;
      end
      ctrl_q    <= CTRL_RST;
      cfg_rdata <= '0;
      cfg_err   <= 1'b0;
    end else begin
      cfg_err <= cfg_valid && !acc_ok;
      if (cfg_valid && !acc_ok) begin
        cfg_rdata <= '0;
      end else if (cfg_valid && !cfg_write) begin
        cfg_rdata <= rd_val;
      end
      if (cfg_valid && cfg_write && acc_ok) begin
        for (int i = 0; i < NWIN; i++) begin
          if (idx == IDX_W'(i))            win_base[i]  <= cfg_wdata;
          if (idx == IDX_W'(NWIN + i))     win_mask[i]  <= cfg_wdata;
          if (idx == IDX_W'(2 * NWIN + i)) win_tbase[i] <= cfg_wdata;
        end
        if (idx == CTRL_IDX) ctrl_q <= cfg_wdata;
      end
    end
  end
endmodule

// File: rtl/pwx_window.sv
module pwx_window
  import pwx_pkg::*;
#(
  parameter int CMP_LO = 20,
  parameter int CMP_HI = 31,
  parameter int PG_SH  = 13,
  parameter int PTE_SH = 3,
  parameter int OUT_W  = 34
) (
  input  logic [DW-1:0] bus_addr,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] tbase,
  output logic          hit,
  output logic          sg,
  output logic [DW-1:0] direct_res,
  output logic [DW-1:0] pte_addr
);
  localparam int SH = PG_SH - PTE_SH;
  localparam logic [DW-1:0] FLD =
    {{(DW-CMP_HI-1){1'b0}}, {(CMP_HI-CMP_LO+1){1'b1}}, {CMP_LO{1'b0}}};
  localparam logic [DW-1:0] LOW_OFF = {{(DW-CMP_LO){1'b0}}, {CMP_LO{1'b1}}};
  localparam logic [DW-1:0] PG_IDX =
    {{(DW-CMP_LO){1'b0}}, {(CMP_LO-PG_SH){1'b1}}, {PG_SH{1'b0}}};
  localparam logic [DW-1:0] TB_CLR =
    {{(DW-CMP_LO+SH){1'b0}}, {(CMP_LO-SH){1'b1}}};
  localparam logic [DW-1:0] OUT_MASK = {{(DW-OUT_W){1'b0}}, {OUT_W{1'b1}}};

  logic [DW-1:0] size_fld;
  logic [DW-1:0] cmp_mask;
  logic [DW-1:0] off_mask;
  logic [DW-1:0] tb_clear;

  assign size_fld = mask & FLD;
  assign cmp_mask = ~mask & FLD;
  assign hit      = base[0] && (((bus_addr ^ base) & cmp_mask) == '0);
  assign sg       = base[1];

  assign off_mask   = size_fld | LOW_OFF;
  assign direct_res = ((tbase & ~off_mask) | (bus_addr & off_mask)) & OUT_MASK;

  assign tb_clear = (size_fld >> SH) | TB_CLR;
  assign pte_addr = (tbase & ~tb_clear) | ((bus_addr & (size_fld | PG_IDX)) >> SH);
endmodule

// File: rtl/pwx_ctrl.sv
module pwx_ctrl
  import pwx_pkg::*;
#(
  parameter int NWIN  = 4,
  parameter int PG_SH = 13,
  parameter int OUT_W = 34
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [DW-1:0]   req_addr,
  input  logic [NWIN-1:0] win_hit,
  input  logic [NWIN-1:0] win_sg,
  input  logic [DW-1:0]   win_direct [NWIN],
  input  logic [DW-1:0]   win_pte    [NWIN],
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_addr,
  output logic            mem_req_valid,
  output logic [DW-1:0]   mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_data
);
  localparam logic [DW-1:0] OUT_MASK = {{(DW-OUT_W){1'b0}}, {OUT_W{1'b1}}};
  localparam logic [DW-1:0] PFN_MASK = ~{{(DW-1){1'b0}}, 1'b1};

  pwx_state_e       state_q;
  logic             accept;
  logic             sel_hit;
  logic             sel_sg;
  logic [DW-1:0]    sel_direct;
  logic [DW-1:0]    sel_pte;
  logic [PG_SH-1:0] pg_off_q;
  logic [DW-1:0]    sg_res;

  always_comb begin
    sel_hit    = 1'b0;
    sel_sg     = 1'b0;
    sel_direct = '0;
    sel_pte    = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        sel_hit    = 1'b1;
        sel_sg     = win_sg[i];
        sel_direct = win_direct[i];
        sel_pte    = win_pte[i];
      end
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign mem_req_valid = (state_q == ST_FETCH);
  assign sg_res = (((mem_rsp_data & PFN_MASK) << (PG_SH - 1)) |
                   {{(DW-PG_SH){1'b0}}, pg_off_q}) & OUT_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      rsp_valid    <= 1'b0;
      rsp_addr     <= '0;
      mem_req_addr <= '0;
      pg_off_q     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (sel_hit && sel_sg) begin
              state_q      <= ST_FETCH;
              mem_req_addr <= sel_pte;
              pg_off_q     <= req_addr[PG_SH-1:0];
            end else begin
              rsp_valid <= 1'b1;
              rsp_addr  <= sel_hit ? sel_direct : req_addr;
            end
          end
        end
        ST_FETCH: begin
          if (mem_rsp_valid) begin
            state_q   <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_addr  <= sg_res;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_win_xlate.sv
module pci_win_xlate
  import pwx_pkg::*;
#(
  parameter int NWIN   = 4,
  parameter int AW     = 10,
  parameter int CMP_LO = 20,
  parameter int CMP_HI = 31,
  parameter int PG_SH  = 13,
  parameter int PTE_SH = 3,
  parameter int OUT_W  = 34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_valid,
  input  logic          cfg_write,
  input  logic [AW-1:0] cfg_addr,
  input  logic [1:0]    cfg_size,
  input  logic [63:0]   cfg_wdata,
  output logic [63:0]   cfg_rdata,
  output logic          cfg_err,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [63:0]   req_addr,
  output logic          rsp_valid,
  output logic [63:0]   rsp_addr,
  output logic          mem_req_valid,
  output logic [63:0]   mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [63:0]   mem_rsp_data
);
  logic [DW-1:0]   base_w   [NWIN];
  logic [DW-1:0]   mask_w   [NWIN];
  logic [DW-1:0]   tbase_w  [NWIN];
  logic [DW-1:0]   direct_w [NWIN];
  logic [DW-1:0]   pte_w    [NWIN];
  logic [NWIN-1:0] hit_w;
  logic [NWIN-1:0] sg_w;

  pwx_regs #(.NWIN(NWIN), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_write (cfg_write),
    .cfg_addr  (cfg_addr),
    .cfg_size  (cfg_size),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_err   (cfg_err),
    .win_base  (base_w),
    .win_mask  (mask_w),
    .win_tbase (tbase_w)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    pwx_window #(
      .CMP_LO(CMP_LO), .CMP_HI(CMP_HI), .PG_SH(PG_SH),
      .PTE_SH(PTE_SH), .OUT_W(OUT_W)
    ) u_win (
      .bus_addr   (req_addr),
      .base       (base_w[g]),
      .mask       (mask_w[g]),
      .tbase      (tbase_w[g]),
      .hit        (hit_w[g]),
      .sg         (sg_w[g]),
      .direct_res (direct_w[g]),
      .pte_addr   (pte_w[g])
    );
  end

  pwx_ctrl #(.NWIN(NWIN), .PG_SH(PG_SH), .OUT_W(OUT_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .win_hit       (hit_w),
    .win_sg        (sg_w),
    .win_direct    (direct_w),
    .win_pte       (pte_w),
    .rsp_valid     (rsp_valid),
    .rsp_addr      (rsp_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
  );
endmodule

// File: rtl/pwx_chk.sv
module pwx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_valid,
  input logic [1:0]  cfg_size,
  input logic [63:0] cfg_rdata,
  input logic        cfg_err,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        mem_req_valid,
  input logic [63:0] mem_req_addr,
  input logic        mem_rsp_valid
);
  // R11: no new request is taken while an entry fetch is outstanding
  p_stall_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R7: the fetch request holds with a stable address until answered
  p_fetch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R8: an answered fetch yields a result in the next cycle and ends the fetch
  p_fetch_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_rsp_valid) |=> (rsp_valid && !mem_req_valid));

  // R11: every result is caused by an acceptance or a fetch answer
  p_rsp_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_req_valid && mem_rsp_valid)));

  // R3: a narrow access is rejected with zero data
  p_bad_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_size != 2'd3) |=> (cfg_err && cfg_rdata == 64'd0));

  // R3: the error flag only follows an access
  p_err_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_valid));
endmodule

bind pci_win_xlate pwx_chk i_pwx_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_valid     (cfg_valid),
  .cfg_size      (cfg_size),
  .cfg_rdata     (cfg_rdata),
  .cfg_err       (cfg_err),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/test_pci_win_xlate.sv
`timescale 1ns/1ps
module test_pci_win_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_write = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [1:0]  cfg_size = 2'd3;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        cfg_err;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic [63:0] rsp_addr;
  logic        mem_req_valid;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pci_win_xlate i_pci_win_xlate (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_err(cfg_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(int idx, logic [63:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = 1'b1; cfg_size = 2'd3;
    cfg_addr = 10'(idx << 6); cfg_wdata = d;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_write = 1'b0;
  endtask

  task automatic cfg_rd(string tag, int idx, logic [63:0] exp);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = 1'b0; cfg_size = 2'd3; cfg_addr = 10'(idx << 6);
    @(negedge clk);
    cfg_valid = 1'b0;
    check(tag, cfg_rdata, exp);
    check({tag, " err"}, 64'(cfg_err), 64'd0);
  endtask

  task automatic xl_direct(string tag, logic [63:0] a, logic [63:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    check({tag, " ready"}, 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, 64'(rsp_valid), 64'd1);
    check(tag, rsp_addr, exp);
  endtask

  task automatic xl_sg(string tag, logic [63:0] a, logic [63:0] exp_pte,
                       logic [63:0] entry, logic [63:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R7 mreq"}, 64'(mem_req_valid), 64'd1);
    check({tag, " R7 pte"}, mem_req_addr, exp_pte);
    check({tag, " R11 stall"}, 64'(req_ready), 64'd0);
    repeat (2) @(negedge clk);
    check({tag, " R7 hold"}, {63'd0, mem_req_valid} | {rsp_valid, 63'd0}, 64'd1);
    mem_rsp_valid = 1'b1; mem_rsp_data = entry;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    check({tag, " R8 valid"}, 64'(rsp_valid), 64'd1);
    check({tag, " R8 addr"}, rsp_addr, exp);
    check({tag, " R8 done"}, 64'(mem_req_valid), 64'd0);
  endtask

  task automatic t_reset;
    check("R1 ready", 64'(req_ready), 64'd1);
    check("R1 rsp", 64'(rsp_valid), 64'd0);
    check("R1 mreq", 64'(mem_req_valid), 64'd0);
    cfg_rd("R1 base0", 0, 64'd0);
    cfg_rd("R1 mask3", 7, 64'd0);
    cfg_rd("R1 tbase2", 10, 64'd0);
    cfg_rd("R1 ctrl", 12, 64'h0000_0021_0010_0000);
  endtask

  task automatic t_program;
    cfg_wr(0, 64'h4000_0001);      cfg_wr(4, 64'h0FF0_0000);  cfg_wr(8,  64'h2_3000_0000);
    cfg_wr(1, 64'h8000_0000);      cfg_wr(5, 64'h0);          cfg_wr(9,  64'h1_0000_0000);
    cfg_wr(2, 64'h8000_0003);      cfg_wr(6, 64'h0010_0000);  cfg_wr(10, 64'h0123_4000);
    cfg_wr(3, 64'h8000_0001);      cfg_wr(7, 64'h3FF0_0000);  cfg_wr(11, 64'h3_C000_0000);
    cfg_wr(12, 64'hDEAD_BEEF_0000_1234);
    cfg_rd("R2 base2", 2, 64'h8000_0003);
    cfg_rd("R2 mask0", 4, 64'h0FF0_0000);
    cfg_rd("R2 tbase3", 11, 64'h3_C000_0000);
    cfg_rd("R2 ctrl", 12, 64'hDEAD_BEEF_0000_1234);
  endtask

  task automatic bad_acc(string tag, bit wr, logic [9:0] a, logic [1:0] sz);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = wr; cfg_addr = a; cfg_size = sz;
    cfg_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_write = 1'b0; cfg_size = 2'd3;
    check({tag, " R3 err"}, 64'(cfg_err), 64'd1);
    check({tag, " R3 data"}, cfg_rdata, 64'd0);
    @(negedge clk);
    check({tag, " R3 one cycle"}, 64'(cfg_err), 64'd0);
  endtask

  task automatic t_bad;
    bad_acc("narrow read", 1'b0, 10'h000, 2'd2);
    bad_acc("narrow write", 1'b1, 10'h000, 2'd1);
    bad_acc("hole read", 1'b0, 10'(13 << 6), 2'd3);
    bad_acc("hole write", 1'b1, 10'(15 << 6), 2'd3);
    bad_acc("unaligned write", 1'b1, 10'h008, 2'd3);
    cfg_rd("R3 base0 unchanged", 0, 64'h4000_0001);
  endtask

  task automatic t_direct;
    xl_direct("R6 w0", 64'h4567_89AB, 64'h2_3567_89AB);
    xl_direct("R4 high bits ignored", 64'hFF_4567_89AB, 64'h2_3567_89AB);
    xl_direct("R4 w3 bit21", 64'h8020_0010, 64'h3_C020_0010);
    xl_direct("R10 miss", 64'hC000_0000, 64'hC000_0000);
    xl_direct("R10 miss wide", 64'h1234_5678_C000_0000, 64'h1234_5678_C000_0000);
  endtask

  task automatic t_sg;
    // R5: w1 is disabled though its address agrees; w2 wins over w3.
    // R9: the raw result 0xA_BCDE_0345 is cut to 34 bits.
    xl_sg("R5 sg w2", 64'h8001_2345, 64'h0123_4048, 64'hAB_CDE1, 64'h2_BCDE_0345);
    cfg_wr(2, 64'h8000_0002);
    xl_direct("R5 w2 disabled", 64'h8001_2345, 64'h3_C001_2345);
  endtask

  task automatic t_b2b;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 64'h4000_0010;
    @(negedge clk);
    check("R11 b2b v1", 64'(rsp_valid), 64'd1);
    check("R11 b2b a1", rsp_addr, 64'h2_3000_0010);
    check("R11 b2b ready", 64'(req_ready), 64'd1);
    req_addr = 64'hC000_0044;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 b2b v2", 64'(rsp_valid), 64'd1);
    check("R11 b2b a2", rsp_addr, 64'hC000_0044);
    @(negedge clk);
    check("R11 idle", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 64'h4567_89AB;
    cfg_valid = 1'b1; cfg_write = 1'b1; cfg_size = 2'd3;
    cfg_addr = 10'(8 << 6); cfg_wdata = 64'h1_0000_0000;
    @(negedge clk);
    req_valid = 1'b0; cfg_valid = 1'b0; cfg_write = 1'b0;
    check("R12 old tbase", rsp_addr, 64'h2_3567_89AB);
    xl_direct("R12 new tbase", 64'h4567_89AB, 64'h1_0567_89AB);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_program;
    t_bad;
    t_direct;
    t_sg;
    t_b2b;
    t_same_cycle;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule